// File: doc/BRIEF.md
# Normalizing Shift-Subtract Divider

This block divides an unsigned 24-bit dividend by an unsigned 16-bit divisor. It gives a 16-bit quotient and the remainder. A request is accepted on `start`. The block runs until it finishes and then pulses `done`, with the results held on its outputs until the next completion.

The work is split into two passes. The first pass is a scaling pass. It subtracts the divisor from a working copy of the dividend, then doubles the divisor, and repeats this until a subtraction borrows. Each step is counted. The working copy is then reloaded with the original dividend. The second pass runs once for each counted step. Each step makes a trial subtraction, keeps the difference only when it does not borrow, and shifts the no-borrow flag into the quotient. It then halves the divisor, except on the final step. Because of this, the run time depends on the operands. Small quotients finish in a few cycles. A divisor of one takes the longest.

A divisor of zero never enters the loop. It is reported through an error flag one cycle after the request.

Top module: `nsd_divider`

## Requirements
- R1: For a nonzero divisor d and dividend N, on completion `quotient` equals the low 16 bits of floor(N/d) and `remainder` equals N mod d.
- R2: Let n be the smallest integer n >= 1 with d*(2^n - 1) > N. Then `done` is high exactly 2n clock edges after the edge that accepted `start`, and `busy` is high for those 2n cycles minus the completion edge.
- R3: If N < d (including N = 0), then n = 1 and the run takes 2 cycles. If N = d, the run takes 4 cycles. If d = 1 and N = 2^24 - 1, the run takes 50 cycles.
- R4: An accepted request with divisor zero asserts `done` and `div_err` one cycle later, with `quotient` all ones, `remainder` zero and `busy` never high.
- R5: A completion with a nonzero divisor has `div_err` low. `div_err` keeps its value until the next accepted request.
- R6: `start` is accepted only when `busy` and `done` are both low. A `start` pulse with other operands during a run changes neither the result nor the completion cycle of that run.
- R7: `done` is high for exactly one cycle per completion and is never high together with `busy`.
- R8: After reset, `busy`, `done` and `div_err` are low and `quotient` and `remainder` are zero.
- R9: `quotient` and `remainder` change only in a cycle where `done` is high, and they hold their values afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division with the present operands |
| dividend | input | 24 | Unsigned dividend, sampled at acceptance |
| divisor | input | 16 | Unsigned divisor, sampled at acceptance |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Last accepted request had a zero divisor |
| quotient | output | 16 | Low bits of the quotient |
| remainder | output | 16 | Remainder of the last completed division |

## Verification
Each result is due a data-dependent number of cycles after the accepting edge: 2n edges for a nonzero divisor and one edge for a zero divisor. The bench computes n from the operands by the same inequality stated in R2. After each accepting edge, the bench counts edges, sampling `done` on the falling edge between them. It compares the edge count at which `done` first appears against that figure. Only then does it read the quotient, remainder and error flag, and two cycles later it checks that they are still held and that `done` has dropped.

// File: rtl/nsd_pkg.sv
`timescale 1ns/1ps
package nsd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NORM = 2'd1,
    ST_QUOT = 2'd2
  } nsd_state_e;
endpackage

// File: rtl/nsd_trial_sub.sv
`timescale 1ns/1ps
module nsd_trial_sub #(
  parameter int W = 25
) (
  input  logic [W-1:0] minuend,
  input  logic [W-1:0] subtrahend,
  output logic [W-1:0] diff,
  output logic         borrow
);
  always_comb begin
    {borrow, diff} = {1'b0, minuend} - {1'b0, subtrahend};
  end
endmodule

// File: rtl/nsd_step_counter.sv
`timescale 1ns/1ps
module nsd_step_counter #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          last
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | inc | dec;
    cnt_d  = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
    else if (dec) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign last = (cnt_q == CW'(1));

  // R2: a decrement never starts from zero
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (cnt_q != '0));
endmodule

// File: rtl/nsd_divider.sv
`timescale 1ns/1ps
module nsd_divider #(
  parameter int DVD_W = 24,
  parameter int DVS_W = 16,
  parameter int QUO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic             div_err,
  output logic [QUO_W-1:0] quotient,
  output logic [DVS_W-1:0] remainder
);
  import nsd_pkg::*;

  localparam int AW = DVD_W + 1;
  localparam int CW = $clog2(DVD_W + 2);

  nsd_state_e       state_q, state_d;
  logic [AW-1:0]    rem_q, rem_d;
  logic [AW-1:0]    dvs_q, dvs_d;
  logic [AW-1:0]    sav_q, sav_d;
  logic [QUO_W-1:0] qsh_q, qsh_d;
  logic [QUO_W-1:0] quo_q, quo_d;
  logic [DVS_W-1:0] rout_q, rout_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic             work_en, res_en, err_en;
  logic             cnt_clr, cnt_inc, cnt_dec;
  logic [CW-1:0]    cnt;
  logic             cnt_last;
  logic [AW-1:0]    diff;
  logic             borrow;
  logic             accept, dvs_zero;

  nsd_trial_sub #(.W(AW)) u_sub (
    .minuend(rem_q), .subtrahend(dvs_q), .diff(diff), .borrow(borrow)
  );

  nsd_step_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .dec(cnt_dec),
    .cnt(cnt), .last(cnt_last)
  );

  assign accept   = start && (state_q == ST_IDLE) && !done_q;
  assign dvs_zero = (divisor == '0);

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    dvs_d   = dvs_q;
    sav_d   = sav_q;
    qsh_d   = qsh_q;
    quo_d   = quo_q;
    rout_d  = rout_q;
    err_d   = err_q;
    done_d  = 1'b0;
    work_en = 1'b0;
    res_en  = 1'b0;
    err_en  = 1'b0;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    cnt_dec = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          err_en = 1'b1;
          err_d  = dvs_zero;
          if (dvs_zero) begin
            done_d = 1'b1;
            res_en = 1'b1;
            quo_d  = '1;
            rout_d = '0;
          end else begin
            work_en = 1'b1;
            cnt_clr = 1'b1;
            state_d = ST_NORM;
            rem_d   = {1'b0, dividend};
            sav_d   = {1'b0, dividend};
            dvs_d   = {{(AW-DVS_W){1'b0}}, divisor};
            qsh_d   = '0;
          end
        end
      end
      ST_NORM: begin
        work_en = 1'b1;
        cnt_inc = 1'b1;
        if (borrow) begin
          state_d = ST_QUOT;
          rem_d   = sav_q;
        end else begin
          rem_d = diff;
          dvs_d = dvs_q << 1;
        end
      end
      ST_QUOT: begin
        work_en = 1'b1;
        cnt_dec = 1'b1;
        if (!borrow) rem_d = diff;
        qsh_d = {qsh_q[QUO_W-2:0], !borrow};
        if (cnt_last) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          res_en  = 1'b1;
          quo_d   = qsh_d;
          rout_d  = rem_d[DVS_W-1:0];
        end else begin
          dvs_d = dvs_q >> 1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      dvs_q <= '0;
      sav_q <= '0;
      qsh_q <= '0;
    end else if (work_en) begin
      rem_q <= rem_d;
      dvs_q <= dvs_d;
      sav_q <= sav_d;
      qsh_q <= qsh_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      rout_q <= '0;
    end else if (res_en) begin
      quo_q  <= quo_d;
      rout_q <= rout_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign div_err   = err_q;
  assign quotient  = quo_q;
  assign remainder = rout_q;

  // R7: completion pulse lasts one cycle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: never busy while signalling completion
  assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  // R4: zero divisor reports next cycle with all-ones quotient
  assert_zero_div_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done && divisor == '0) |=> (done && div_err && quotient == '1 && !busy));
  // R9: results only move on a completion
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder)));
  // R1: remainder is below the divisor on a good completion
  assert_rem_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_err) |-> ({{(AW-DVS_W){1'b0}}, remainder} < dvs_q));
  // R6: saved operand untouched by start pulses during a run
  assert_ignore_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(sav_q));
  // R2: scaling pass never runs past the dividend width
  assert_norm_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NORM) |-> (cnt <= CW'(DVD_W)));
endmodule

// File: tb/nsd_divider_tb.sv
`timescale 1ns/1ps
module nsd_divider_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic        busy, done, div_err;
  logic [15:0] quotient, remainder;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  nsd_divider u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .div_err(div_err), .quotient(quotient), .remainder(remainder)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int steps(input longint n, input longint d);
    int k = 1;
    while (d * ((64'd1 << k) - 1) <= n) k++;
    return k;
  endfunction

  task automatic run_op(input logic [23:0] n, input logic [15:0] d, input bit inject);
    int lat = 0;
    int exp_lat;
    logic [15:0] q_exp, r_exp, q_hold, r_hold;
    bit busy_bad = 1'b0;
    @(negedge clk);
    dividend = n; divisor = d; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    while (!done && lat < 200) begin
      if (inject && lat == 1) begin
        start = 1'b1; dividend = ~n; divisor = d ^ 16'h00A5;
      end else start = 1'b0;
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    if (busy) busy_bad = 1'b1;
    if (d == 0) begin
      exp_lat = 0; q_exp = 16'hFFFF; r_exp = 16'h0000;
    end else begin
      exp_lat = 2 * steps(longint'(n), longint'(d));
      q_exp = 16'(longint'(n) / longint'(d));
      r_exp = 16'(longint'(n) % longint'(d));
    end
    // R2 R3 R4 R6: completion cycle
    chk(lat == exp_lat, inject ? "R6" : (d == 0 ? "R4" : "R2"), "latency", lat, exp_lat);
    // R1 R4: values
    chk(quotient == q_exp, d == 0 ? "R4" : "R1", "quotient", quotient, q_exp);
    chk(remainder == r_exp, d == 0 ? "R4" : "R1", "remainder", remainder, r_exp);
    chk(div_err == (d == 0), d == 0 ? "R4" : "R5", "div_err", div_err, (d == 0));
    chk(!busy_bad, "R7", "busy at done", busy, 0);
    q_hold = quotient; r_hold = remainder;
    @(negedge clk);
    chk(!done, "R7", "done second cycle", done, 0);
    @(negedge clk);
    chk(quotient == q_hold && remainder == r_hold, "R9", "held result",
        {quotient, remainder}, {q_hold, r_hold});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(!busy && !done && !div_err, "R8", "flags", {busy, done, div_err}, 0);
    chk(quotient == 0 && remainder == 0, "R8", "results", {quotient, remainder}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3: boundary runs
    run_op(24'hFFFFFF, 16'd1, 1'b0);
    run_op(24'd1234, 16'd1234, 1'b0);
    run_op(24'd5, 16'd9, 1'b0);
    run_op(24'd0, 16'd7, 1'b0);
    run_op(24'hFFFFFF, 16'hFFFF, 1'b0);
    run_op(24'd673312, 16'd881, 1'b0);
    // R4: zero divisor, also back to back
    run_op(24'd100, 16'd0, 1'b0);
    run_op(24'd0, 16'd0, 1'b0);
    // R5: good run after an error clears the flag
    run_op(24'd100, 16'd3, 1'b0);
    // R6: start pulses during runs are ignored
    run_op(24'd50000, 16'd3, 1'b1);
    run_op(24'hABCDEF, 16'd1, 1'b1);
    run_op(24'd999, 16'd10, 1'b1);
    // R1: exhaustive small sweep
    for (int d = 1; d < 16; d++)
      for (int n = 0; n < 64; n++)
        run_op(24'(n), 16'(d), 1'b0);
    // R1 R2: powers of two and neighbours
    for (int s = 0; s < 16; s++) begin
      run_op(24'hFFFFFF, 16'(1 << s), 1'b0);
      run_op(24'(1 << (s + 8)), 16'((1 << s) + 1), 1'b0);
      run_op(24'((1 << (s + 8)) - 1), 16'(1 << s), 1'b0);
    end
    // R1: wide operands
    for (int i = 0; i < 300; i++)
      run_op(24'($urandom), 16'($urandom | 1), 1'b0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule